// File: doc/BRIEF.md
# Regulator Fault Qualifier and Reset Generator

This block watches the raw overvoltage and undervoltage comparator outputs of one regulator rail. Each comparator output goes through its own deglitch filter, which counts pulses of a 1 µs time-base enable. A condition is accepted only after it has stayed present through a fixed number of those pulses. An accepted condition sets a sticky flag that the host reads and clears. The block never turns the regulator off. The decision to shut down belongs to the processor, and the control loop is free to recover on its own in the meantime.

Fault qualification is masked in two cases. The first is while soft start has not finished. The second is while a dynamic voltage scaling transition is active and has not yet reported completion. Any count built up during a mask is thrown away, so filtering starts fresh once the mask lifts. The active-low reset output stays low until soft start is done. It is released one clock later if no qualified condition is present, and it drops again when a qualified condition appears.

Top module: `reg_fault_qual`

## Requirements
- R1: A raw OV or UV input must be high on N_TICKS (default 20) consecutive `tick_i` pulses, with no mask in between. The internal qualified condition appears in the cycle after the clock edge that takes the N_TICKS-th pulse. The matching flag is set at the next edge. If the input stays high through only N_TICKS-1 pulses, no flag is set.
- R2: When the raw input goes low before the count reaches N_TICKS, the count returns to zero. A later high period must again collect the full N_TICKS pulses.
- R3: While `dvs_active_i` is 1 and `dvs_done_i` is 0, no flag is set and no pulses are counted.
- R4: While `ss_done_i` is 0, no flag is set and no pulses are counted. `rst_no` is 0 in the cycle after any edge at which `ss_done_i` is 0.
- R5: `rst_no` takes the value 1 at the first clock edge where `ss_done_i` is 1 and neither channel has a qualified condition. It takes the value 0 one clock after a qualified condition becomes present.
- R6: `ov_flag_o` and `uv_flag_o` stay set until `clr_i` is seen high at a clock edge. When a set and a clear occur at the same edge, the set wins.
- R7: `fault_o` is 1 exactly when either `ov_flag_o` or `uv_flag_o` is 1. The block has no output that acts on the regulator.
- R8: When a mask lifts, filtering starts from zero. N_TICKS new pulses with the raw input high are needed before a flag is set, no matter how long the input was high during the mask.
- R9: While `rst_ni` is low, both flags, `fault_o` and `rst_no` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Single-cycle 1 µs time-base enable |
| ov_raw_i | input | 1 | Raw overvoltage comparator output |
| uv_raw_i | input | 1 | Raw undervoltage comparator output |
| ss_done_i | input | 1 | Soft start complete |
| dvs_active_i | input | 1 | Voltage scaling transition in progress |
| dvs_done_i | input | 1 | Voltage scaling transition reported done |
| clr_i | input | 1 | Flag clear strobe from the register interface |
| ov_flag_o | output | 1 | Sticky qualified overvoltage flag |
| uv_flag_o | output | 1 | Sticky qualified undervoltage flag |
| fault_o | output | 1 | Either flag set |
| rst_no | output | 1 | Active-low reset, released when the rail is in regulation |

## Verification
The assertions check, on every cycle, several rules. Reset is held low when soft start is not done. Reset is released only after soft start is done and no condition is qualified. A flag is set only from an unmasked qualified condition. Flags stay sticky except when cleared. A mask always removes a qualified condition by the following cycle. The filter length can only be shown by the bench's scenarios. These include the miss after N_TICKS-1 pulses, a restart after a raw dropout, and a full restart after a voltage scaling mask lifts. The exact one-clock release of reset and the random mix of ticks, masks and clears are also checked there, against a per-cycle model.

// File: rtl/fq_pkg.sv
package fq_pkg;
  localparam int unsigned N_CH = 2;
  typedef enum logic [0:0] {CH_OV = 1'b0, CH_UV = 1'b1} fq_ch_e;
endpackage

// File: rtl/fq_filter.sv
module fq_filter #(
  parameter int unsigned N_TICKS = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic raw_i,
  input  logic mask_i,
  output logic qual_o
);
  localparam int unsigned CW = $clog2(N_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(N_TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (mask_i || !raw_i)          cnt_q <= '0;
    else if (tick_i && (cnt_q < LIMIT)) cnt_q <= cnt_q + 1'b1;
  end

  assign qual_o = (cnt_q == LIMIT);
endmodule

// File: rtl/fq_flag.sv
module fq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;   // set beats clear
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/fq_rst_gen.sv
module fq_rst_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ss_done_i,
  input  logic any_qual_i,
  output logic rst_no
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_no <= 1'b0;
    else         rst_no <= ss_done_i && !any_qual_i;
  end
endmodule

// File: rtl/reg_fault_qual.sv
module reg_fault_qual
  import fq_pkg::*;
#(
  parameter int unsigned N_TICKS = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic ov_raw_i,
  input  logic uv_raw_i,
  input  logic ss_done_i,
  input  logic dvs_active_i,
  input  logic dvs_done_i,
  input  logic clr_i,
  output logic ov_flag_o,
  output logic uv_flag_o,
  output logic fault_o,
  output logic rst_no
);
  logic [N_CH-1:0] raw, qual, flag;
  logic            mask;

  assign raw[CH_OV] = ov_raw_i;
  assign raw[CH_UV] = uv_raw_i;

  // soft start pending, or scaling in flight without done status
  assign mask = !ss_done_i || (dvs_active_i && !dvs_done_i);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    fq_filter #(.N_TICKS(N_TICKS)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .raw_i  (raw[c]),
      .mask_i (mask),
      .qual_o (qual[c])
    );
    fq_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (qual[c] && !mask),
      .clr_i  (clr_i),
      .flag_o (flag[c])
    );
  end

  fq_rst_gen u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ss_done_i  (ss_done_i),
    .any_qual_i (|qual),
    .rst_no     (rst_no)
  );

  assign ov_flag_o = flag[CH_OV];
  assign uv_flag_o = flag[CH_UV];
  assign fault_o   = |flag;
endmodule

// File: rtl/fq_checker.sv
module fq_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ov_raw_i,
  input logic       uv_raw_i,
  input logic       ss_done_i,
  input logic       clr_i,
  input logic       ov_flag_o,
  input logic       uv_flag_o,
  input logic       rst_no,
  input logic [1:0] qual_i,
  input logic       mask_i
);
  AST_RST_HELD_IN_SS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ss_done_i |=> !rst_no); // R4
  AST_RST_RELEASE_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> $past(ss_done_i && (qual_i == 2'b00))); // R5
  AST_QUAL_NEEDS_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(qual_i[0]) |-> $past(ov_raw_i)) and ($rose(qual_i[1]) |-> $past(uv_raw_i))); // R1
  AST_MASK_DROPS_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_i |=> (qual_i == 2'b00)); // R8
  AST_OV_SET_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ov_flag_o) |-> $past(qual_i[0] && !mask_i)); // R3
  AST_UV_SET_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(uv_flag_o) |-> $past(qual_i[1] && !mask_i)); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ov_flag_o && !clr_i) |=> ov_flag_o); // R6
  AST_FLAG_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(qual_i[1] && !mask_i)) |=> !uv_flag_o); // R6
endmodule

bind reg_fault_qual fq_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ov_raw_i  (ov_raw_i),
  .uv_raw_i  (uv_raw_i),
  .ss_done_i (ss_done_i),
  .clr_i     (clr_i),
  .ov_flag_o (ov_flag_o),
  .uv_flag_o (uv_flag_o),
  .rst_no    (rst_no),
  .qual_i    (qual),
  .mask_i    (mask)
);

// File: tb/reg_fault_qual_tb.sv
module reg_fault_qual_tb;
  localparam int unsigned N = 20;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic tick_i = 0, ov_raw_i = 0, uv_raw_i = 0, ss_done_i = 0;
  logic dvs_active_i = 0, dvs_done_i = 0, clr_i = 0;
  logic ov_flag_o, uv_flag_o, fault_o, rst_no;

  int checks = 0, failures = 0;
  bit done = 0;

  // bench model state
  int  m_cnt [2];
  bit  m_flag[2];
  bit  m_rstn;

  always #5 clk_i = ~clk_i;

  reg_fault_qual #(.N_TICKS(N)) u_dut (.*);

  function automatic bit f_mask(bit ss, bit da, bit dd);
    return !ss || (da && !dd);
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act{fault,ov,uv,rstn}=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit mk, q[2], raw[2];
    mk = f_mask(ss_done_i, dvs_active_i, dvs_done_i);
    raw[0] = ov_raw_i; raw[1] = uv_raw_i;
    for (int c = 0; c < 2; c++) q[c] = (m_cnt[c] == N);
    m_rstn = ss_done_i && !q[0] && !q[1];
    for (int c = 0; c < 2; c++) begin
      if (q[c] && !mk) m_flag[c] = 1;
      else if (clr_i)  m_flag[c] = 0;
      if (mk || !raw[c])              m_cnt[c] = 0;
      else if (tick_i && m_cnt[c] < N) m_cnt[c]++;
    end
  endtask

  function automatic logic [3:0] exp_vec();
    return {m_flag[0] | m_flag[1], m_flag[0], m_flag[1], m_rstn};
  endfunction

  task automatic step(string tag, bit t, bit ov, bit uv, bit ss, bit da, bit dd, bit cl);
    tick_i = t; ov_raw_i = ov; uv_raw_i = uv; ss_done_i = ss;
    dvs_active_i = da; dvs_done_i = dd; clr_i = cl;
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    check(tag, {fault_o, ov_flag_o, uv_flag_o, rst_no}, exp_vec());
  endtask

  task automatic expect1(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    #1500000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit ov, uv, ss, da, dd;
    void'($urandom(32'd1234));
    m_cnt[0] = 0; m_cnt[1] = 0; m_flag[0] = 0; m_flag[1] = 0; m_rstn = 0;
    ov_raw_i = 1; tick_i = 1;
    repeat (3) @(negedge clk_i);
    check("R9 reset state", {fault_o, ov_flag_o, uv_flag_o, rst_no}, 4'b0000);
    rst_ni = 1'b1;

    // R4: soft start pending masks faults and holds reset
    for (int i = 0; i < 30; i++) step("R4", 1, 1, 1, 0, 0, 0, 0);
    expect1("R4 ov_flag", ov_flag_o, 0);
    expect1("R4 rst_no", rst_no, 0);

    // R5: release one clock after soft start done
    step("R5", 0, 0, 0, 1, 0, 0, 0);
    expect1("R5 release", rst_no, 1);

    // R1/R2: N-1 ticks then dropout
    for (int i = 0; i < N - 1; i++) step("R1", 1, 1, 0, 1, 0, 0, 0);
    step("R2", 0, 0, 0, 1, 0, 0, 0);
    expect1("R2 no flag after dropout", ov_flag_o, 0);
    for (int i = 0; i < N; i++) step("R2", 1, 1, 0, 1, 0, 0, 0);
    expect1("R1 flag after N ticks", ov_flag_o, 0);
    step("R1", 1, 1, 0, 1, 0, 0, 0);
    expect1("R1 flag set", ov_flag_o, 1);
    expect1("R7 fault", fault_o, 1);
    expect1("R5 reset drops", rst_no, 0);

    // R6: sticky, then clear
    for (int i = 0; i < 5; i++) step("R6", 0, 0, 0, 1, 0, 0, 0);
    expect1("R6 sticky", ov_flag_o, 1);
    step("R6", 0, 0, 0, 1, 0, 0, 1);
    expect1("R6 cleared", ov_flag_o, 0);
    expect1("R7 fault cleared", fault_o, 0);

    // R3: scaling mask
    for (int i = 0; i < 40; i++) step("R3", 1, 0, 1, 1, 1, 0, 0);
    expect1("R3 uv masked", uv_flag_o, 0);
    // R8: restart after mask lifts
    for (int i = 0; i < N; i++) step("R8", 1, 0, 1, 1, 1, 1, 0);
    expect1("R8 restart", uv_flag_o, 0);
    step("R8", 1, 0, 1, 1, 1, 1, 0);
    expect1("R8 set after restart", uv_flag_o, 1);
    step("R6", 1, 0, 1, 1, 1, 1, 1);
    expect1("R6 set wins", uv_flag_o, 1);

    // random mix
    ov = 0; uv = 0; ss = 1; da = 0; dd = 0;
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(63) == 0) ov = !ov;
      if ($urandom_range(63) == 0) uv = !uv;
      if ($urandom_range(255) == 0) ss = !ss;
      if ($urandom_range(127) == 0) da = !da;
      dd = da ? ($urandom_range(7) == 0 ? 1'b1 : dd) : 1'b0;
      step("R7 random", $urandom_range(1) == 1, ov, uv, ss, da, dd,
           $urandom_range(31) == 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule